// File: doc/BRIEF.md
# Two-Wire Dual Wiper Register Port

This block is a bus slave for a two-wire serial bus (clock and open-drain data), clocked by a much faster system clock. It holds the 6-bit tap codes of a dual-channel stepped attenuator and presents both codes as plain level outputs to the downstream ladder-control logic. Both bus lines are oversampled through two-flop synchronizers. Start, repeated start and stop conditions are detected from the synchronized levels, and a serial engine handles addressing, writes, reads and acknowledges.

A transfer opens with a control byte. Its upper nibble is the fixed device-type code 0101, the next three bits must equal the strapped address pins, and bit 0 selects read (1) or write (0). Data bytes then go to, or come from, the two wiper codes in turn. The slave only ever pulls the data line low, through an output enable. An active-low port enable disconnects the whole interface. The wiper outputs are levels with no valid/ready handshake. The bus master cannot be stalled because clock stretching is not used, so there is no back-pressure anywhere in the block.

Top module: `wiper_port`

## Requirements
- R1: After reset both wiper codes equal 33, the mute code, and the data-line enable is released (0).
- R2: A control byte whose bits 7..4 are 0101 and whose bits 3..1 equal addr_i is acknowledged: the slave holds the data line low for the whole high phase of the ninth clock.
- R3: A control byte with a wrong type code or wrong address bits is not acknowledged, and all later bytes are ignored until the next start.
- R4: In a write, the first data byte after the control byte goes to wiper 0 and the second to wiper 1. Later bytes alternate between the two channels, every byte is acknowledged, and one byte changes at most one wiper.
- R5: A written value above 33 is stored as 33. Values 0 through 33 are stored unchanged.
- R6: In a read, the slave sends bytes {2'b00, code} MSB first, starting with wiper 0 and alternating, for as long as the master acknowledges. After a not-acknowledge it leaves the data line released.
- R7: A stop returns the slave to idle and releases the data line. Bytes clocked after a stop without a new start are not acknowledged and change nothing.
- R8: A repeated start ends the current transfer and begins a new control byte. The channel order restarts at wiper 0.
- R9: While port_en_n is 1, the slave never drives the data line and the wiper codes do not change, whatever the bus does.
- R10: The data-line enable is asserted only while the bus clock is low. The slave changes its output after a falling clock edge, and data is sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en_n | input | 1 | Active-low port enable; 1 disconnects the bus interface |
| addr_i | input | 3 | Strapped device address compared with control byte bits 3..1 |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| wiper0_o | output | 6 | Tap code of channel 0 |
| wiper1_o | output | 6 | Tap code of channel 1 |

## Verification
The assertions assume a well-behaved master. Each bus phase lasts several system clocks longer than the synchronizer delay, so a falling clock seen by the slave is still low when its output enable rises. The data line changes only while the clock is low, except for deliberate start and stop conditions. The assertions also assume port_en_n changes only while the bus is idle. The stimulus holds every bus phase for ten system clocks. It moves the data line only in the middle of low phases, and it toggles port_en_n only between transfers with both lines high.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WIPER_W   = 6;
  localparam int MUTE_CODE = 33;
  localparam int NUM_CH    = 2;
  localparam int SEL_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int SYNC_STG  = 2;
  localparam logic [3:0] TYPE_CODE = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } wp_state_e;
endpackage

// File: rtl/wp_bus_sync.sv
module wp_bus_sync #(
  parameter int STAGES = wp_pkg::SYNC_STG
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  // data edges during a steady-high clock are bus conditions
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise_ev  = scl_s & ~scl_q;
  assign fall_ev  = ~scl_s & scl_q;
endmodule

// File: rtl/wp_wiper_bank.sv
module wp_wiper_bank #(
  parameter int NUM_CH    = wp_pkg::NUM_CH,
  parameter int WIPER_W   = wp_pkg::WIPER_W,
  parameter int MUTE_CODE = wp_pkg::MUTE_CODE,
  parameter int BYTE_W    = wp_pkg::BYTE_W,
  parameter int SEL_W     = wp_pkg::SEL_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [BYTE_W-1:0]               wr_byte,
  output logic [NUM_CH-1:0][WIPER_W-1:0]  codes
);
  localparam logic [WIPER_W-1:0] MUTE_V = WIPER_W'(MUTE_CODE);
  localparam logic [BYTE_W-1:0]  LIMIT  = BYTE_W'(MUTE_CODE);

  logic [WIPER_W-1:0] clamped;
  assign clamped = (wr_byte > LIMIT) ? MUTE_V : wr_byte[WIPER_W-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        codes[ch] <= MUTE_V;
      else if (wr_en && (wr_sel == SEL_W'(ch)))
        codes[ch] <= clamped;
    end
  end
endmodule

// File: rtl/wp_engine.sv
module wp_engine
  import wp_pkg::*;
#(
  parameter int BYTE_W = wp_pkg::BYTE_W,
  parameter int ADDR_W = wp_pkg::ADDR_W,
  parameter int SEL_W  = wp_pkg::SEL_W,
  parameter int NUM_CH = wp_pkg::NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_byte,
  output logic [SEL_W-1:0]  sel,
  output logic              oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  wp_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  sh;
  logic               ack_on;
  logic               rnw;
  logic [BYTE_W-1:0]  in_byte;
  logic               hit;
  logic               live;
  logic [SEL_W-1:0]   sel_next;

  assign in_byte  = {sh[BYTE_W-2:0], sda_s};
  assign hit      = (in_byte[BYTE_W-1:BYTE_W-4] == TYPE_CODE) &&
                    (in_byte[ADDR_W:1] == addr_i);
  assign live     = en & ~start_ev & ~stop_ev;
  assign sel_next = (sel == SEL_W'(NUM_CH - 1)) ? '0 : sel + SEL_W'(1);

  assign wr_en   = live && (state == ST_WR) && rise_ev && (cnt == LAST_BIT);
  assign wr_byte = in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ack_on <= 1'b0;
      rnw    <= 1'b0;
      sel    <= '0;
      oe     <= 1'b0;
    end else if (!en) begin
      state  <= ST_IDLE;
      ack_on <= 1'b0;
      oe     <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_CTRL;
      cnt    <= '0;
      ack_on <= 1'b0;
      oe     <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      ack_on <= 1'b0;
      oe     <= 1'b0;
    end else begin
      case (state)
        ST_CTRL: begin
          if (rise_ev) begin
            sh  <= in_byte;
            cnt <= cnt + CNT_W'(1);
            if (cnt == LAST_BIT) begin
              if (hit) begin
                state  <= ST_CACK;
                rnw    <= sda_s;
                sel    <= '0;
                ack_on <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_CACK: begin
          if (fall_ev) begin
            if (!ack_on) begin
              oe     <= 1'b1;
              ack_on <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              cnt    <= '0;
              if (rnw) begin
                state <= ST_RD;
                sh    <= rd_byte;
                oe    <= ~rd_byte[BYTE_W-1];
              end else begin
                state <= ST_WR;
                oe    <= 1'b0;
              end
            end
          end
        end
        ST_WR: begin
          if (rise_ev) begin
            sh  <= in_byte;
            cnt <= cnt + CNT_W'(1);
            if (cnt == LAST_BIT) begin
              state  <= ST_WACK;
              ack_on <= 1'b0;
              sel    <= sel_next;
            end
          end
        end
        ST_WACK: begin
          if (fall_ev) begin
            if (!ack_on) begin
              oe     <= 1'b1;
              ack_on <= 1'b1;
            end else begin
              oe     <= 1'b0;
              ack_on <= 1'b0;
              cnt    <= '0;
              state  <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (fall_ev) begin
            if (cnt == LAST_BIT) begin
              state <= ST_RACK;
              oe    <= 1'b0;
            end else begin
              cnt <= cnt + CNT_W'(1);
              sh  <= {sh[BYTE_W-2:0], sh[BYTE_W-1]};
              oe  <= ~sh[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (rise_ev) begin
            if (sda_s) begin
              state <= ST_IDLE;
            end else begin
              ack_on <= 1'b1;
              sel    <= sel_next;
            end
          end else if (fall_ev && ack_on) begin
            ack_on <= 1'b0;
            cnt    <= '0;
            state  <= ST_RD;
            sh     <= rd_byte;
            oe     <= ~rd_byte[BYTE_W-1];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wiper_port.sv
module wiper_port
  import wp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o
);
  logic scl_s, sda_s, start_ev, stop_ev, rise_ev, fall_ev;
  logic wr_en;
  logic [BYTE_W-1:0] wr_byte, rd_byte;
  logic [SEL_W-1:0] sel;
  logic [NUM_CH-1:0][WIPER_W-1:0] codes;

  wp_bus_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  wp_engine u_engine (
    .clk(clk), .rst_n(rst_n), .en(~port_en_n),
    .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .sda_s(sda_s), .addr_i(addr_i), .rd_byte(rd_byte),
    .wr_en(wr_en), .wr_byte(wr_byte), .sel(sel), .oe(sda_oe)
  );

  wp_wiper_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel),
    .wr_byte(wr_byte), .codes(codes)
  );

  assign rd_byte  = {{(BYTE_W-WIPER_W){1'b0}}, codes[sel]};
  assign wiper0_o = codes[0];
  assign wiper1_o = codes[1];
endmodule

// File: rtl/wp_checker.sv
module wp_checker
  import wp_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               port_en_n,
  input logic               sda_oe,
  input logic               scl_s,
  input logic               stop_ev,
  input logic [WIPER_W-1:0] wiper0_o,
  input logic [WIPER_W-1:0] wiper1_o
);
  localparam logic [WIPER_W-1:0] MUTE_V = WIPER_W'(MUTE_CODE);

  assert_mute_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wiper0_o == MUTE_V && wiper1_o == MUTE_V && !sda_oe));

  assert_single_channel_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(wiper0_o) && !$stable(wiper1_o)));

  assert_code_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper0_o <= MUTE_V) && (wiper1_o <= MUTE_V));

  assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_oe && $stable(wiper0_o) && $stable(wiper1_o)));

  assert_disabled_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en_n && $past(port_en_n)) |-> !sda_oe);

  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(port_en_n) |-> ($stable(wiper0_o) && $stable(wiper1_o)));

  assert_drive_in_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));
endmodule

bind wiper_port wp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .port_en_n(port_en_n), .sda_oe(sda_oe),
  .scl_s(scl_s), .stop_ev(stop_ev), .wiper0_o(wiper0_o), .wiper1_o(wiper1_o)
);

// File: tb/wiper_port_tb.sv
module wiper_port_tb;
  localparam int H = 10;
  localparam logic [2:0] ADDR = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m_low = 1'b0;
  logic sda_oe;
  logic [5:0] wiper0_o, wiper1_o;
  logic sda_line;

  assign sda_line = ~(sda_m_low | sda_oe);

  always #4 clk = ~clk;

  wiper_port u_dut (
    .clk(clk), .rst_n(rst_n), .port_en_n(port_en_n), .addr_i(ADDR),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .wiper0_o(wiper0_o), .wiper1_o(wiper1_o)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit settled = 1;
  bit prev_oe = 0;
  int exp_w[2] = '{33, 33};
  int m_phase = 0;   // 0 idle, 1 control byte, 2 write, 3 read
  int m_ptr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int clamp33(input int v);
    return (v > 33) ? 33 : v;
  endfunction

  // reference model compared on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (settled) begin
        check(int'(wiper0_o) == exp_w[0], "R4", "wiper0 model", int'(wiper0_o), exp_w[0]);
        check(int'(wiper1_o) == exp_w[1], "R4", "wiper1 model", int'(wiper1_o), exp_w[1]);
      end
      if (port_en_n)
        check(!sda_oe, "R9", "drive while disabled", int'(sda_oe), 0);
      if (sda_oe && !prev_oe)
        check(!scl, "R10", "scl at drive start", int'(scl), 0);
      prev_oe = sda_oe;
    end
  end

  task automatic m_start();
    sda_m_low = 0; wait_h(H);
    scl = 1;       wait_h(H);
    sda_m_low = 1; wait_h(H);
    scl = 0;       wait_h(H);
    m_phase = 1;
  endtask

  task automatic m_stop();
    scl = 0;       wait_h(H/2);
    sda_m_low = 1; wait_h(H/2);
    scl = 1;       wait_h(H);
    sda_m_low = 0; wait_h(H);
    m_phase = 0;
  endtask

  task automatic m_send(input logic [7:0] b, input string tag);
    bit exp_ack;
    bit got_ack;
    settled = 0;
    exp_ack = 0;
    if (m_phase == 1) begin
      exp_ack = !port_en_n && (b[7:4] == 4'b0101) && (b[3:1] == ADDR);
    end else if (m_phase == 2) begin
      exp_ack = 1;
    end
    for (int i = 7; i >= 0; i--) begin
      scl = 0;          wait_h(H/2);
      sda_m_low = !b[i]; wait_h(H/2);
      scl = 1;          wait_h(H);
    end
    scl = 0;       wait_h(H/2);
    sda_m_low = 0; wait_h(H/2);
    scl = 1;       wait_h(H/2);
    got_ack = !sda_line;
    wait_h(H/2);
    scl = 0;       wait_h(H/2);
    check(got_ack == exp_ack, tag, "ack", int'(got_ack), int'(exp_ack));
    if (m_phase == 1) begin
      if (exp_ack) begin
        m_phase = b[0] ? 3 : 2;
        m_ptr = 0;
      end else begin
        m_phase = 0;
      end
    end else if (m_phase == 2) begin
      exp_w[m_ptr] = clamp33(int'(b));
      m_ptr = 1 - m_ptr;
    end
    settled = 1;
  endtask

  task automatic m_recv(input bit mack, input string tag);
    logic [7:0] got;
    int exp_b;
    exp_b = (m_phase == 3) ? exp_w[m_ptr] : 255;
    sda_m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      scl = 0; wait_h(H);
      scl = 1; wait_h(H/2);
      got[i] = sda_line;
      wait_h(H/2);
    end
    scl = 0;          wait_h(H/2);
    sda_m_low = mack; wait_h(H/2);
    scl = 1;          wait_h(H);
    scl = 0;          wait_h(H/2);
    sda_m_low = 0;    wait_h(H/2);
    check(int'(got) == exp_b, tag, "read byte", int'(got), exp_b);
    if (m_phase == 3) begin
      if (mack) m_ptr = 1 - m_ptr;
      else m_phase = 0;
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(0, "R1", "watchdog expired", cyc, 150000);
        finish_sim();
      end
    end
  end

  initial begin
    wait_h(5);
    rst_n = 1;
    wait_h(2);
    // R1: reset state
    check(int'(wiper0_o) == 33, "R1", "wiper0 reset", int'(wiper0_o), 33);
    check(int'(wiper1_o) == 33, "R1", "wiper1 reset", int'(wiper1_o), 33);
    check(!sda_oe, "R1", "oe reset", int'(sda_oe), 0);

    // R2 control byte ack; R4 alternation; R5 clamp of 50
    m_start();
    m_send(8'h5A, "R2");
    m_send(8'd5, "R4");
    m_send(8'd50, "R5");
    check(int'(wiper1_o) == 33, "R5", "clamped 50", int'(wiper1_o), 33);
    m_send(8'd20, "R4");
    m_send(8'd7, "R4");
    m_stop();
    check(int'(wiper0_o) == 20, "R4", "wiper0 after four", int'(wiper0_o), 20);
    check(int'(wiper1_o) == 7, "R4", "wiper1 after four", int'(wiper1_o), 7);

    // R6: read with ack, ack, nack
    m_start();
    m_send(8'h5B, "R2");
    m_recv(1, "R6");
    m_recv(1, "R6");
    m_recv(0, "R6");
    wait_h(H);
    check(!sda_oe, "R6", "released after nack", int'(sda_oe), 0);
    m_stop();

    // R3: wrong address, then wrong type code
    m_start();
    m_send(8'h5C, "R3");
    m_send(8'd11, "R3");
    m_stop();
    m_start();
    m_send(8'h7A, "R3");
    m_send(8'd12, "R3");
    m_stop();
    check(int'(wiper0_o) == 20, "R3", "wiper0 untouched", int'(wiper0_o), 20);

    // R7: stop right after control byte, then bytes with no start
    m_start();
    m_send(8'h5A, "R2");
    m_stop();
    m_send(8'd2, "R7");
    m_send(8'd3, "R7");
    m_stop();
    check(int'(wiper0_o) == 20 && int'(wiper1_o) == 7, "R7", "wipers after stray bytes",
          int'(wiper0_o), 20);

    // R8: write, repeated start, read back from wiper 0
    m_start();
    m_send(8'h5A, "R2");
    m_send(8'd9, "R4");
    m_start();
    m_send(8'h5B, "R8");
    m_recv(1, "R8");
    m_recv(0, "R8");
    m_stop();

    // R9: disabled port ignores a full write
    port_en_n = 1;
    wait_h(H);
    m_start();
    m_send(8'h5A, "R9");
    m_send(8'd1, "R9");
    m_stop();
    port_en_n = 0;
    wait_h(H);
    check(int'(wiper0_o) == 9, "R9", "wiper0 held", int'(wiper0_o), 9);

    // R5 boundaries 33 and 34, then 0 and 32
    m_start();
    m_send(8'h5A, "R2");
    m_send(8'd33, "R5");
    m_send(8'd34, "R5");
    check(int'(wiper1_o) == 33, "R5", "clamped 34", int'(wiper1_o), 33);
    m_send(8'd0, "R5");
    m_send(8'd32, "R5");
    m_stop();
    m_start();
    m_send(8'h5B, "R2");
    m_recv(1, "R6");
    m_recv(0, "R6");
    m_stop();

    wait_h(H);
    finish_sim();
  end
endmodule